// File: doc/BRIEF.md
# Sequential Restoring Divider

A multi-cycle integer divider that produces one quotient bit per clock. It uses one subtractor the width of an operand and a single double-width working register. The dividend enters the lower half of that register and is shifted left once before the loop starts. On each step the divisor is trial-subtracted from the upper half. A non-negative difference is kept and a 1 is shifted into the bottom of the register. A negative difference leaves the upper half as it was, and a 0 is shifted in. After the last step the lower half holds the quotient. The upper half, moved one place right, holds the remainder.

A signed mode divides the operand magnitudes and then corrects the signs. The quotient rounds toward zero, and the remainder takes the sign of the dividend. A zero divisor is not treated as an exception. The run takes the normal number of cycles and returns a defined result. The block takes a one-cycle start request while it is idle. It raises a one-cycle done pulse and keeps the results on its outputs until the next accepted start.

Top module: `seq_divider`

## Requirements
- R1: After reset, busy_o and done_o are 0 and lo_o and hi_o are both 0.
- R2: A start_i sampled high while busy_o is 0 sets busy_o from the next cycle. done_o is high for exactly one cycle, 32 clock edges after the accepting edge, and busy_o falls in that same cycle.
- R3: With signed_i low, the operands are unsigned. lo_o carries the quotient and hi_o the remainder of dividend_i / divisor_i. This holds when either operand has bit 31 set.
- R4: With signed_i high, the operands are two's complement. The quotient is truncated toward zero, and a nonzero remainder has the sign of the dividend.
- R5: An unsigned divide by zero gives lo_o = 0xFFFFFFFF and hi_o = dividend.
- R6: A signed divide by zero gives hi_o = dividend. lo_o is 0xFFFFFFFF for a non-negative dividend and 0x00000001 for a negative one.
- R7: start_i while busy_o is 1 is ignored. The running division finishes on schedule with the results of its own operands.
- R8: lo_o and hi_o keep the last results while idle, until a new start is accepted.
- R9: The signed division 0x80000000 / 0xFFFFFFFF gives lo_o = 0x80000000 and hi_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend, sampled on the accepting edge |
| divisor_i | input | 32 | Divisor, sampled on the accepting edge |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| lo_o | output | 32 | Quotient |
| hi_o | output | 32 | Remainder |

## Verification
A bad quotient bit or a dropped bit at the top of the partial remainder does not show while the block runs. It shows only on lo_o and hi_o in the done cycle, 32 edges after start. Operands are therefore chosen so that the divisor has bit 31 set, the dividend is all ones, or signs are mixed, which routes errors into visible result bits. A wrong step counter or a start accepted while busy shows as busy_o or done_o out of step with a reference model compared on every clock. A fault in the hold logic shows as results changing during idle cycles.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_sign_prep.sv
module div_sign_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  input  logic         signed_i,
  output logic [W-1:0] dvd_mag_o,
  output logic [W-1:0] dvs_mag_o,
  output logic         neg_quo_o,
  output logic         neg_rem_o
);
  logic dvd_neg, dvs_neg;

  always_comb begin
    dvd_neg   = signed_i & dividend_i[W-1];
    dvs_neg   = signed_i & divisor_i[W-1];
    dvd_mag_o = dvd_neg ? (~dividend_i + 1'b1) : dividend_i;
    dvs_mag_o = dvs_neg ? (~divisor_i + 1'b1) : divisor_i;
    neg_quo_o = dvd_neg ^ dvs_neg;
    neg_rem_o = dvd_neg;
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 32,
  localparam int RW = 2 * W
) (
  input  logic          ext_i,
  input  logic [RW-1:0] rem_i,
  input  logic [W-1:0]  dvs_i,
  output logic          ext_o,
  output logic [RW-1:0] rem_o
);
  logic [W+1:0] diff;
  logic         too_small;

  always_comb begin
    // ext_i extends the upper half so a shifted partial remainder never loses its top bit
    diff      = {1'b0, ext_i, rem_i[RW-1:W]} - {2'b00, dvs_i};
    // a true difference is below the divisor, so either high bit means borrow
    too_small = diff[W+1] | diff[W];
    if (too_small) begin
      ext_o = rem_i[RW-1];
      rem_o = {rem_i[RW-2:0], 1'b0};
    end else begin
      ext_o = diff[W-1];
      rem_o = {diff[W-2:0], rem_i[W-1:0], 1'b1};
    end
  end
endmodule

// File: rtl/div_fixup.sv
module div_fixup #(
  parameter int W = 32
) (
  input  logic         ext_i,
  input  logic [W-2:0] hi_top_i,
  input  logic [W-1:0] quo_mag_i,
  input  logic         neg_quo_i,
  input  logic         neg_rem_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] rem_mag;

  always_comb begin
    rem_mag = {ext_i, hi_top_i};
    quo_o   = neg_quo_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
    rem_o   = neg_rem_i ? (~rem_mag + 1'b1) : rem_mag;
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int W = 32,
  localparam int RW = 2 * W,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  div_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] rem_q, rem_nxt;
  logic          ext_q, ext_nxt;
  logic [W-1:0]  dvs_q;
  logic          neg_quo_q, neg_rem_q, sgn_q, done_q;

  logic [W-1:0]  dvd_mag, dvs_mag;
  logic          neg_quo, neg_rem;
  logic          accept;

  assign accept = start_i && (state_q == DIV_IDLE);

  div_sign_prep #(.W(W)) u_prep (
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .signed_i  (signed_i),
    .dvd_mag_o (dvd_mag),
    .dvs_mag_o (dvs_mag),
    .neg_quo_o (neg_quo),
    .neg_rem_o (neg_rem)
  );

  div_step #(.W(W)) u_step (
    .ext_i(ext_q),
    .rem_i(rem_q),
    .dvs_i(dvs_q),
    .ext_o(ext_nxt),
    .rem_o(rem_nxt)
  );

  div_fixup #(.W(W)) u_fix (
    .ext_i    (ext_q),
    .hi_top_i (rem_q[RW-1:W+1]),
    .quo_mag_i(rem_q[W-1:0]),
    .neg_quo_i(neg_quo_q),
    .neg_rem_i(neg_rem_q),
    .quo_o    (lo_o),
    .rem_o    (hi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= DIV_IDLE;
      cnt_q     <= '0;
      rem_q     <= '0;
      ext_q     <= 1'b0;
      dvs_q     <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      sgn_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q   <= DIV_RUN;
        cnt_q     <= CW'(W);
        rem_q     <= {{(W-1){1'b0}}, dvd_mag, 1'b0};
        ext_q     <= 1'b0;
        dvs_q     <= dvs_mag;
        neg_quo_q <= neg_quo;
        neg_rem_q <= neg_rem;
        sgn_q     <= signed_i;
      end else if (state_q == DIV_RUN) begin
        rem_q <= rem_nxt;
        ext_q <= ext_nxt;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          state_q <= DIV_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign busy_o = (state_q == DIV_RUN);
  assign done_o = done_q;

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_rem_below_dvs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !sgn_q && dvs_q != '0) |-> (hi_o < dvs_q));
  assert_zero_div_quo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !sgn_q && dvs_q == '0) |-> (lo_o == '1));
  assert_busy_ignores_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != CW'(1)) |=> busy_o);
  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(lo_o) && $stable(hi_o)));
endmodule

// File: tb/seq_divider_tb.sv
module seq_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sgn = 1'b0;
  logic [31:0] dvd = '0;
  logic [31:0] dvs = '0;
  logic        busy, done;
  logic [31:0] lo, hi;

  int    errors = 0;
  int    checks = 0;
  string cur_tag = "R3";

  logic        exp_busy, exp_done;
  logic [31:0] exp_lo, exp_hi, pend_lo, pend_hi;
  int          exp_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_divider u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .dividend_i(dvd), .divisor_i(dvs),
    .busy_o(busy), .done_o(done), .lo_o(lo), .hi_o(hi)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_div(input logic [31:0] a, input logic [31:0] d,
                                  input logic s, output logic [31:0] q,
                                  output logic [31:0] r);
    longint la, ld;
    if (d == 0) begin
      r = a;
      q = (s && a[31]) ? 32'h1 : 32'hFFFF_FFFF;
    end else if (s) begin
      la = longint'(int'(a));
      ld = longint'(int'(d));
      q  = 32'(la / ld);
      r  = 32'(la % ld);
    end else begin
      q = a / d;
      r = a % d;
    end
  endfunction

  // cycle-level reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_busy <= 1'b0; exp_done <= 1'b0; exp_cnt <= 0;
      exp_lo <= '0; exp_hi <= '0; pend_lo <= '0; pend_hi <= '0;
    end else begin
      logic [31:0] q, r;
      exp_done <= 1'b0;
      if (!exp_busy && start) begin
        ref_div(dvd, dvs, sgn, q, r);
        pend_lo  <= q;
        pend_hi  <= r;
        exp_busy <= 1'b1;
        exp_cnt  <= 32;
      end else if (exp_busy) begin
        exp_cnt <= exp_cnt - 1;
        if (exp_cnt == 1) begin
          exp_busy <= 1'b0;
          exp_done <= 1'b1;
          exp_lo   <= pend_lo;
          exp_hi   <= pend_hi;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "busy", {31'b0, busy}, {31'b0, exp_busy});
      chk("R2", "done", {31'b0, done}, {31'b0, exp_done});
      if (!exp_busy) begin
        chk(exp_done ? cur_tag : "R8", "lo", lo, exp_lo);
        chk(exp_done ? cur_tag : "R8", "hi", hi, exp_hi);
      end
    end
  end

  task automatic run_div(input string tag, input logic s,
                         input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cur_tag = tag;
    sgn = s; dvd = a; dvs = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (34) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy", {31'b0, busy}, 32'h0);
    chk("R1", "done", {31'b0, done}, 32'h0);
    chk("R1", "lo", lo, 32'h0);
    chk("R1", "hi", hi, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_div("R3", 1'b0, 32'd100, 32'd7);
    run_div("R3", 1'b0, 32'hFFFF_FFFF, 32'd3);
    run_div("R3", 1'b0, 32'hFFFF_FFFF, 32'h8000_0001);
    run_div("R3", 1'b0, 32'h8000_0000, 32'hFFFF_FFFF);
    run_div("R3", 1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    run_div("R3", 1'b0, 32'd0, 32'd5);
    run_div("R3", 1'b0, 32'hDEAD_BEEF, 32'd1);
    run_div("R4", 1'b1, -32'sd7, 32'd2);
    run_div("R4", 1'b1, 32'd7, -32'sd2);
    run_div("R4", 1'b1, -32'sd7, -32'sd2);
    run_div("R4", 1'b1, 32'h7FFF_FFFF, 32'd10);
    run_div("R5", 1'b0, 32'hCAFE_F00D, 32'd0);
    run_div("R6", 1'b1, 32'd5, 32'd0);
    run_div("R6", 1'b1, -32'sd5, 32'd0);
    run_div("R9", 1'b1, 32'h8000_0000, 32'hFFFF_FFFF);

    // R7: second start mid-run must not disturb the division in flight
    @(negedge clk);
    cur_tag = "R7";
    sgn = 1'b0; dvd = 32'd1000; dvs = 32'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    dvd = 32'd55; dvs = 32'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk("R7", "lo", lo, 32'd111);
    chk("R7", "hi", hi, 32'd1);

    // R8: idle with changing inputs and no start
    dvd = 32'h1234_5678; dvs = 32'd3; sgn = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8", "lo", lo, 32'd111);
    chk("R8", "hi", hi, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog actual=%0d expected<%0d cycles", WATCHDOG, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule